// File: doc/BRIEF.md
# Fractional-N PLL Setting Solver

This block turns a reference clock rate and a wanted output rate into a full
set of fractional-N PLL settings. It also takes two hardware limits: the highest
rate allowed at the phase detector and the lowest rate the oscillator may run
at. From these it produces the following values:

- the reference pre-divider;
- the integer and 18-bit fractional feedback multipliers;
- the output post-divider;
- a sigma-delta setting;
- the phase-detector rate, oscillator rate and output rate that these settings actually give.

The post-divider is chosen so that the oscillator stays at or above its floor.
The feedback multiplier is then split into an integer part and a fraction scaled
by 2^18.

A one-cycle `start` captures the four input rates. A single shared radix-2
divider then runs eight divisions in turn, each step named by its own state:

- `ST_IDLE` waits for `start` and moves to `ST_NDIV` when it arrives.
- `ST_NDIV` computes the pre-divider.
- `ST_FINT` computes the phase-detector rate.
- `ST_DCOMIN` rounds the oscillator floor.
- `ST_M2` computes the post-divider.
- `ST_MINT` computes the integer multiplier and its remainder.
- `ST_MFRAC` computes the fraction.
- `ST_OUT` computes the output rate.
- `ST_SD` computes the sigma-delta setting.
- `ST_FINISH` publishes the results and pulses `done`, then returns to `ST_IDLE`.

Each division state moves to the next one on the cycle the divider reports completion.

Top module: `fracpll_solver`

## Requirements
- R1: After reset, `done` is low and every result output is zero.
- R2: `n_div` = ceil(`clkin_rate` / `fint_max`), and `fint_rate` = floor(`clkin_rate` / `n_div`).
- R3: The oscillator floor `dco_min` is first rounded up to the next whole multiple of `fint_rate`. `m2_div` = ceil(that rounded floor / `target_rate`).
- R4: When that ceiling is zero (a zero floor), `m2_div` is 1. `m2_div` is never zero in a published result.
- R5: `m_int` = floor(`target_rate` × `m2_div` / `fint_rate`). `m_frac` = floor(2^18 × rem / `fint_rate`), where rem = `target_rate` × `m2_div` − `fint_rate` × `m_int`. `m_frac` is 0 if rem exceeds `fint_rate`.
- R6: `dco_rate` = `fint_rate` × `m_int` + floor(`m_frac` × `fint_rate` / 2^18), and `out_rate` = floor(`dco_rate` / `m2_div`).
- R7: `sd_val` = ceil(`fint_rate` × `m_int` / SD_STEP), with SD_STEP = 250,000,000 by default. An exact multiple gives no round-up.
- R8: `done` is high for exactly one cycle per computation, and all results change on that cycle only. They hold until the next result is published.
- R9: The input rates are sampled on the `start` cycle. A `start` that arrives while a computation is running is ignored: it neither restarts the solver nor produces an extra result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation (used only when idle) |
| clkin_rate | input | RATE_W | Reference clock rate |
| target_rate | input | RATE_W | Wanted output rate |
| fint_max | input | RATE_W | Highest allowed phase-detector rate |
| dco_min | input | RATE_W | Lowest allowed oscillator rate |
| done | output | 1 | One-cycle result-valid pulse |
| n_div | output | RATE_W | Reference pre-divider |
| m_int | output | RATE_W | Integer feedback multiplier |
| m_frac | output | FRAC_W | Fractional feedback multiplier (scaled by 2^18) |
| m2_div | output | RATE_W | Output post-divider |
| sd_val | output | RATE_W | Sigma-delta setting |
| fint_rate | output | RATE_W | Resulting phase-detector rate |
| dco_rate | output | RATE_W | Resulting oscillator rate |
| out_rate | output | RATE_W | Resulting output rate |

## Verification
The bench builds the solver with its default parameters: 32-bit rates, an
18-bit fraction and a 250,000,000 sigma-delta step. With these, real-world
reference and pixel-clock rates fit exactly, and the expected values can be
worked out with plain 64-bit arithmetic.

The chosen rates cover several corner cases:

- a reference slower than the phase-detector limit, so the pre-divider is 1;
- a zero oscillator floor, which forces the post-divider to 1;
- a floor that is already a multiple of the phase-detector rate;
- a target above the floor;
- an integer product that is an exact multiple of the sigma-delta step;
- non-zero fractional remainders.

A second `start` is also sent during a computation, with different rates, to show that it is ignored.

// File: rtl/fracpll_solver_pkg.sv
package fracpll_solver_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_NDIV,
        ST_FINT,
        ST_DCOMIN,
        ST_M2,
        ST_MINT,
        ST_MFRAC,
        ST_OUT,
        ST_SD,
        ST_FINISH
    } solve_state_e;

endpackage

// File: rtl/fracpll_div.sv
module fracpll_div #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt;
    logic          busy;
    logic [W-1:0]  q_r;
    logic [W:0]    r_r;
    logic [W-1:0]  d_r;
    logic [W:0]    trial;
    logic          fits;

    // One restoring step: shift in the next dividend bit, try the subtract.
    always_comb begin
        trial = {r_r[W-1:0], q_r[W-1]};
        fits  = trial >= {1'b0, d_r};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
            q_r  <= '0;
            r_r  <= '0;
            d_r  <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                q_r  <= dividend;
                r_r  <= '0;
                d_r  <= divisor;
                cnt  <= CW'(W);
                busy <= 1'b1;
            end else if (busy) begin
                r_r <= fits ? (trial - {1'b0, d_r}) : trial;
                q_r <= {q_r[W-2:0], fits};
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = q_r;
    assign rem  = r_r[W-1:0];

endmodule

// File: rtl/fracpll_opsel.sv
module fracpll_opsel
    import fracpll_solver_pkg::*;
#(
    parameter int RATE_W  = 32,
    parameter int FRAC_W  = 18,
    parameter int SD_STEP = 250_000_000
) (
    input  solve_state_e          state,
    input  logic [RATE_W-1:0]     in_clkin,
    input  logic [RATE_W-1:0]     in_tgt,
    input  logic [RATE_W-1:0]     in_fmax,
    input  logic [RATE_W-1:0]     in_dmin,
    input  logic [2*RATE_W-1:0]   w_n,
    input  logic [2*RATE_W-1:0]   w_fint,
    input  logic [2*RATE_W-1:0]   w_mdco,
    input  logic [2*RATE_W-1:0]   w_m2,
    input  logic [2*RATE_W-1:0]   w_m,
    input  logic [2*RATE_W-1:0]   w_rem,
    input  logic [2*RATE_W-1:0]   w_dco,
    output logic [2*RATE_W-1:0]   div_a,
    output logic [2*RATE_W-1:0]   div_b
);
    localparam int WIDE_W = 2 * RATE_W;
    localparam logic [WIDE_W-1:0] STEP_W = WIDE_W'(SD_STEP);

    logic [WIDE_W-1:0] clkin_w, tgt_w, fmax_w, dmin_w;

    assign clkin_w = WIDE_W'(in_clkin);
    assign tgt_w   = WIDE_W'(in_tgt);
    assign fmax_w  = WIDE_W'(in_fmax);
    assign dmin_w  = WIDE_W'(in_dmin);

    // Ceilings are formed as floor((a + b - 1) / b).
    always_comb begin
        div_a = '0;
        div_b = '0;
        unique case (state)
            ST_NDIV:   begin div_a = clkin_w + fmax_w - 1'b1;  div_b = fmax_w; end
            ST_FINT:   begin div_a = clkin_w;                  div_b = w_n;    end
            ST_DCOMIN: begin div_a = dmin_w + w_fint - 1'b1;   div_b = w_fint; end
            ST_M2:     begin div_a = w_mdco + tgt_w - 1'b1;    div_b = tgt_w;  end
            ST_MINT:   begin div_a = tgt_w * w_m2;             div_b = w_fint; end
            ST_MFRAC:  begin div_a = w_rem << FRAC_W;          div_b = w_fint; end
            ST_OUT:    begin div_a = w_dco;                    div_b = w_m2;   end
            ST_SD:     begin div_a = w_fint * w_m + STEP_W - 1'b1; div_b = STEP_W; end
            ST_IDLE, ST_FINISH: begin div_a = '0; div_b = '0; end
            default:   begin div_a = '0; div_b = '0; end
        endcase
    end

endmodule

// File: rtl/fracpll_solver.sv
module fracpll_solver
    import fracpll_solver_pkg::*;
#(
    parameter int RATE_W  = 32,
    parameter int FRAC_W  = 18,
    parameter int SD_STEP = 250_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RATE_W-1:0] clkin_rate,
    input  logic [RATE_W-1:0] target_rate,
    input  logic [RATE_W-1:0] fint_max,
    input  logic [RATE_W-1:0] dco_min,
    output logic              done,
    output logic [RATE_W-1:0] n_div,
    output logic [RATE_W-1:0] m_int,
    output logic [FRAC_W-1:0] m_frac,
    output logic [RATE_W-1:0] m2_div,
    output logic [RATE_W-1:0] sd_val,
    output logic [RATE_W-1:0] fint_rate,
    output logic [RATE_W-1:0] dco_rate,
    output logic [RATE_W-1:0] out_rate
);
    localparam int WIDE_W = 2 * RATE_W;

    solve_state_e state, state_nx;
    logic         kick;

    logic [RATE_W-1:0] in_clkin, in_tgt, in_fmax, in_dmin;
    logic [WIDE_W-1:0] w_n, w_fint, w_mdco, w_m2, w_m, w_rem, w_mf, w_dco, w_out, w_sd;
    logic [WIDE_W-1:0] div_a, div_b, div_q, div_r;
    logic              div_done;
    logic [WIDE_W-1:0] mf_pick, m2_pick;

    fracpll_opsel #(
        .RATE_W (RATE_W),
        .FRAC_W (FRAC_W),
        .SD_STEP(SD_STEP)
    ) u_opsel (
        .state   (state),
        .in_clkin(in_clkin),
        .in_tgt  (in_tgt),
        .in_fmax (in_fmax),
        .in_dmin (in_dmin),
        .w_n     (w_n),
        .w_fint  (w_fint),
        .w_mdco  (w_mdco),
        .w_m2    (w_m2),
        .w_m     (w_m),
        .w_rem   (w_rem),
        .w_dco   (w_dco),
        .div_a   (div_a),
        .div_b   (div_b)
    );

    fracpll_div #(.W(WIDE_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (kick),
        .dividend(div_a),
        .divisor (div_b),
        .done    (div_done),
        .quot    (div_q),
        .rem     (div_r)
    );

    // Zero post-divider is replaced by 1; fraction is cleared on an oversized remainder.
    always_comb begin
        m2_pick = (div_q == '0) ? WIDE_W'(1) : div_q;
        mf_pick = (w_rem > w_fint) ? '0 : div_q;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start)    state_nx = ST_NDIV;
            ST_NDIV:   if (div_done) state_nx = ST_FINT;
            ST_FINT:   if (div_done) state_nx = ST_DCOMIN;
            ST_DCOMIN: if (div_done) state_nx = ST_M2;
            ST_M2:     if (div_done) state_nx = ST_MINT;
            ST_MINT:   if (div_done) state_nx = ST_MFRAC;
            ST_MFRAC:  if (div_done) state_nx = ST_OUT;
            ST_OUT:    if (div_done) state_nx = ST_SD;
            ST_SD:     if (div_done) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Datapath captures and published outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kick      <= 1'b0;
            done      <= 1'b0;
            in_clkin  <= '0;
            in_tgt    <= '0;
            in_fmax   <= '0;
            in_dmin   <= '0;
            w_n       <= '0;
            w_fint    <= '0;
            w_mdco    <= '0;
            w_m2      <= '0;
            w_m       <= '0;
            w_rem     <= '0;
            w_mf      <= '0;
            w_dco     <= '0;
            w_out     <= '0;
            w_sd      <= '0;
            n_div     <= '0;
            m_int     <= '0;
            m_frac    <= '0;
            m2_div    <= '0;
            sd_val    <= '0;
            fint_rate <= '0;
            dco_rate  <= '0;
            out_rate  <= '0;
        end else begin
            kick <= 1'b0;
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        in_clkin <= clkin_rate;
                        in_tgt   <= target_rate;
                        in_fmax  <= fint_max;
                        in_dmin  <= dco_min;
                        kick     <= 1'b1;
                    end
                end
                ST_NDIV:   if (div_done) begin w_n    <= div_q;          kick <= 1'b1; end
                ST_FINT:   if (div_done) begin w_fint <= div_q;          kick <= 1'b1; end
                ST_DCOMIN: if (div_done) begin w_mdco <= div_q * w_fint; kick <= 1'b1; end
                ST_M2:     if (div_done) begin w_m2   <= m2_pick;        kick <= 1'b1; end
                ST_MINT: begin
                    if (div_done) begin
                        w_m   <= div_q;
                        w_rem <= div_r;
                        kick  <= 1'b1;
                    end
                end
                ST_MFRAC: begin
                    if (div_done) begin
                        w_mf  <= mf_pick;
                        w_dco <= w_fint * w_m + ((mf_pick * w_fint) >> FRAC_W);
                        kick  <= 1'b1;
                    end
                end
                ST_OUT:    if (div_done) begin w_out <= div_q; kick <= 1'b1; end
                ST_SD:     if (div_done) w_sd <= div_q;
                ST_FINISH: begin
                    done      <= 1'b1;
                    n_div     <= w_n[RATE_W-1:0];
                    m_int     <= w_m[RATE_W-1:0];
                    m_frac    <= w_mf[FRAC_W-1:0];
                    m2_div    <= w_m2[RATE_W-1:0];
                    sd_val    <= w_sd[RATE_W-1:0];
                    fint_rate <= w_fint[RATE_W-1:0];
                    dco_rate  <= w_dco[RATE_W-1:0];
                    out_rate  <= w_out[RATE_W-1:0];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fracpll_solver_chk.sv
module fracpll_solver_chk #(
    parameter int RATE_W  = 32,
    parameter int FRAC_W  = 18,
    parameter int SD_STEP = 250_000_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic [RATE_W-1:0] n_div,
    input logic [RATE_W-1:0] m_int,
    input logic [FRAC_W-1:0] m_frac,
    input logic [RATE_W-1:0] m2_div,
    input logic [RATE_W-1:0] sd_val,
    input logic [RATE_W-1:0] fint_rate,
    input logic [RATE_W-1:0] dco_rate,
    input logic [RATE_W-1:0] out_rate
);
    localparam int WIDE_W = 2 * RATE_W;

    logic [WIDE_W-1:0] base_w, dco_w, out_m2_w, step_w, sd_hi_w, sd_lo_w;

    always_comb begin
        base_w   = WIDE_W'(fint_rate) * WIDE_W'(m_int);
        dco_w    = WIDE_W'(dco_rate);
        out_m2_w = WIDE_W'(out_rate) * WIDE_W'(m2_div);
        step_w   = WIDE_W'(SD_STEP);
        sd_hi_w  = WIDE_W'(sd_val) * step_w;
        sd_lo_w  = (sd_val == '0) ? '0 : (WIDE_W'(sd_val) - 1'b1) * step_w;
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({n_div, m_int, m_frac, m2_div, sd_val, fint_rate, dco_rate, out_rate}));

    // R4
    m2_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> m2_div != '0);

    // R6
    dco_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dco_w >= base_w) && (dco_w - base_w < WIDE_W'(fint_rate)));

    // R6
    out_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_m2_w <= dco_w) && (dco_w - out_m2_w < WIDE_W'(m2_div)));

    // R7
    sd_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sd_hi_w >= base_w) && (sd_lo_w < base_w || base_w == '0));

    logic unused_ok;
    assign unused_ok = ^{n_div, m_frac};

endmodule

bind fracpll_solver fracpll_solver_chk #(
    .RATE_W (RATE_W),
    .FRAC_W (FRAC_W),
    .SD_STEP(SD_STEP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .n_div    (n_div),
    .m_int    (m_int),
    .m_frac   (m_frac),
    .m2_div   (m2_div),
    .sd_val   (sd_val),
    .fint_rate(fint_rate),
    .dco_rate (dco_rate),
    .out_rate (out_rate)
);

// File: tb/fracpll_solver_test.sv
module fracpll_solver_test;

    localparam int RATE_W = 32;
    localparam int FRAC_W = 18;
    localparam longint unsigned STEP = 250_000_000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [RATE_W-1:0] clkin_rate = '0, target_rate = '0, fint_max = '0, dco_min = '0;
    logic              done;
    logic [RATE_W-1:0] n_div, m_int, m2_div, sd_val, fint_rate, dco_rate, out_rate;
    logic [FRAC_W-1:0] m_frac;

    always #2 clk = ~clk;

    fracpll_solver uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .clkin_rate(clkin_rate), .target_rate(target_rate),
        .fint_max(fint_max), .dco_min(dco_min),
        .done(done), .n_div(n_div), .m_int(m_int), .m_frac(m_frac),
        .m2_div(m2_div), .sd_val(sd_val), .fint_rate(fint_rate),
        .dco_rate(dco_rate), .out_rate(out_rate)
    );

    typedef struct packed {
        longint unsigned n, m, mf, m2, sd, fint, dco, outr;
    } expect_t;

    expect_t exp_q[$];
    expect_t last_exp;
    int checks = 0;
    int errors = 0;
    int results_seen = 0;
    int results_issued = 0;

    task automatic check(input bit ok, input string tag, input longint unsigned act,
                         input longint unsigned expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic expect_t model(input longint unsigned ci, tg, fm, dm);
        expect_t e;
        longint unsigned md, td, rem;
        e.n    = (ci + fm - 1) / fm;
        e.fint = ci / e.n;
        md     = ((dm + e.fint - 1) / e.fint) * e.fint;
        e.m2   = (md + tg - 1) / tg;
        if (e.m2 == 0) e.m2 = 1;
        td     = tg * e.m2;
        e.m    = td / e.fint;
        rem    = td - e.fint * e.m;
        e.mf   = (rem > e.fint) ? 0 : (rem << 18) / e.fint;
        e.dco  = e.fint * e.m + ((e.mf * e.fint) >> 18);
        e.outr = e.dco / e.m2;
        e.sd   = (e.fint * e.m + STEP - 1) / STEP;
        return e;
    endfunction

    // Monitor: compare each published result against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && done) begin
            expect_t e;
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected result", 1, 0);
            end else begin
                e = exp_q.pop_front();
                last_exp = e;
                check(n_div == e.n[RATE_W-1:0], "R2 n_div", n_div, e.n);
                check(fint_rate == e.fint[RATE_W-1:0], "R2 fint_rate", fint_rate, e.fint);
                check(m2_div == e.m2[RATE_W-1:0], "R3 m2_div", m2_div, e.m2);
                check(m_int == e.m[RATE_W-1:0], "R5 m_int", m_int, e.m);
                check(m_frac == e.mf[FRAC_W-1:0], "R5 m_frac", m_frac, e.mf);
                check(dco_rate == e.dco[RATE_W-1:0], "R6 dco_rate", dco_rate, e.dco);
                check(out_rate == e.outr[RATE_W-1:0], "R6 out_rate", out_rate, e.outr);
                check(sd_val == e.sd[RATE_W-1:0], "R7 sd_val", sd_val, e.sd);
            end
            results_seen++;
        end
    end

    task automatic launch(input longint unsigned ci, tg, fm, dm);
        exp_q.push_back(model(ci, tg, fm, dm));
        results_issued++;
        @(negedge clk);
        clkin_rate = RATE_W'(ci); target_rate = RATE_W'(tg);
        fint_max = RATE_W'(fm);   dco_min = RATE_W'(dm);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R9: scramble the inputs right after start; result must not change.
        clkin_rate = 32'd7; target_rate = 32'd3; fint_max = 32'd1; dco_min = 32'd5;
    endtask

    task automatic wait_result();
        while (results_seen < results_issued) @(negedge clk);
    endtask

    task automatic run_case(input longint unsigned ci, tg, fm, dm);
        launch(ci, tg, fm, dm);
        wait_result();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done == 1'b0, "R1 done", done, 0);
        check({n_div, m_int, m_frac, m2_div, sd_val, fint_rate, dco_rate, out_rate} == '0,
              "R1 outputs", n_div, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_case(19_200_000, 148_500_000, 2_500_000, 500_000_000);  // fractional mid-range
        run_case(27_000_000, 74_250_000, 2_500_000, 750_000_000);   // non-integer fint
        run_case(10_000_000, 123_456_789, 5_000_000, 0);            // R4 zero floor -> m2=1
        check(m2_div == 32'd1, "R4 m2 forced", m2_div, 1);
        run_case(1_000_000, 333_333_333, 4_000_000, 400_000_000);   // R2 n_div=1
        check(n_div == 32'd1, "R2 n one", n_div, 1);
        run_case(20_000_000, 600_000_000, 2_000_000, 400_000_000);  // R3 target above floor
        check(m2_div == 32'd1, "R3 m2 one", m2_div, 1);
        run_case(20_000_000, 500_000_000, 2_000_000, 400_000_000);  // R7 exact multiple
        check(sd_val == 32'd2, "R7 exact sd", sd_val, 2);

        // R9: a start while computing is ignored.
        launch(38_400_000, 297_000_000, 2_500_000, 1_000_000_000);
        repeat (100) @(negedge clk);
        clkin_rate = 32'd12_000_000; target_rate = 32'd25_000_000;
        fint_max = 32'd1_000_000;    dco_min = 32'd900_000_000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_result();

        // R8: done pulse width and hold after completion.
        @(negedge clk);
        check(done == 1'b0, "R8 done width", done, 0);
        repeat (700) @(negedge clk);
        check(results_seen == results_issued, "R9 no extra result", results_seen, results_issued);
        check(out_rate == last_exp.outr[RATE_W-1:0], "R8 hold out_rate", out_rate, last_exp.outr);
        check(m_int == last_exp.m[RATE_W-1:0], "R8 hold m_int", m_int, last_exp.m);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200_000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", results_seen, results_issued);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule